// File: doc/BRIEF.md
# Chained Timer Pair with Internal Trigger Link

Two up-counting timers share one clock. The first (the master) counts from zero up to a programmable reload value, wraps to zero and starts again. On each pass it produces an internal trigger. A mode field picks what that trigger carries: a pulse on each wrap, the level of a compare output, or a constant low. The second timer (the slave) picks one of its internal trigger inputs and, in its external-clock mode, advances by one on each rising edge of that input. With the update pulse selected, the master acts as a prescaler for the slave. The slave then counts master overflows.

Each timer has its own enable. Only the wrap-pulse and compare-output trigger sources are built. On the slave side only the external-clock mode advances the counter. The other master and slave mode codes are kept as encodings and leave the slave idle.

Top module: `tmr_chain_link`

## Requirements
- R1: While `rstN` is low, both `mstCount` and `slvCount` are zero.
- R2: On each clock edge with `mstEn`=1, `mstCount` rises by one. On the edge where it equals `mstReload`, it becomes 0 instead. With `mstEn`=0 it holds.
- R3: With `mstMode`=3'b010, the trigger is a one-cycle pulse while `mstEn`=1 and `mstCount`==`mstReload`. The slave advances on the same edge where the master wraps, so it counts the overflows that occur while both timers are enabled.
- R4: With `mstMode`[2]=1 (3'b100 to 3'b111), the trigger is the compare level `mstCount` >= `mstCmp`. The slave advances once on each rising edge of that level, which is the edge after `mstCount` first equals `mstCmp` in a period.
- R5: With `mstMode` 3'b000, 3'b001 or 3'b011, the trigger stays low and the slave never advances.
- R6: Only `slvTrigSel`=3'b100 connects the slave to the master trigger. Codes 3'b101 to 3'b111 select unused inputs tied low, and codes 3'b0xx select nothing. With any code other than 3'b100 the slave holds.
- R7: Only `slvMode`=3'b111 (external clock) lets the slave advance. Every other code holds `slvCount`.
- R8: A trigger rising edge seen while `slvEn`=0 is lost, including one that falls in the very cycle in which `slvEn` drops.
- R9: With `mstReload`=0 in mode 3'b010, the trigger stays high while the master is enabled. The slave advances once and then holds.
- R10: `slvCount` wraps to zero after 2^W increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mstEn | input | 1 | Master counter enable |
| slvEn | input | 1 | Slave counter enable |
| mstMode | input | 3 | Master trigger-output source select |
| slvTrigSel | input | 3 | Slave internal trigger select |
| slvMode | input | 3 | Slave mode (3'b111 = external clock) |
| mstReload | input | W | Master auto-reload value |
| mstCmp | input | W | Master compare value |
| mstCount | output | W | Master counter value |
| slvCount | output | W | Slave counter value |

## Verification
The master wrap and the slave increment take effect on the same clock edge. The bench samples just after the overflow edge and expects `mstCount`=0 together with the new `slvCount`. A second collision is `slvEn` falling in the cycle that carries the update pulse. The bench clears `slvEn` right before the overflow edge and expects the master to wrap while the slave keeps its old value.

// File: rtl/tmr_chain_pkg.sv
package tmr_chain_pkg;
  // master trigger-output source codes
  localparam logic [2:0] MMS_NONE   = 3'b000;
  localparam logic [2:0] MMS_UPDATE = 3'b010;
  // slave codes
  localparam logic [2:0] SMS_EXTCLK = 3'b111;
  localparam int         NUM_ITR    = 4;

  typedef struct packed {
    logic mstInc;
    logic mstClr;
    logic slvInc;
  } ctlStrobes_t;
endpackage

// File: rtl/tmr_chain_ctl.sv
module tmr_chain_ctl
  import tmr_chain_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         mstEn,
  input  logic         slvEn,
  input  logic [2:0]   mstMode,
  input  logic [2:0]   slvTrigSel,
  input  logic [2:0]   slvMode,
  input  logic [W-1:0] mstReload,
  input  logic [W-1:0] mstCmp,
  input  logic [W-1:0] mstCount,
  output ctlStrobes_t  strobes
);
  localparam int SEL_W = $clog2(NUM_ITR);

  logic updEvt;
  logic cmpOut;
  logic mstTrg;
  logic [NUM_ITR-1:0] itrVec;
  logic slvTrgIn;
  logic trgPrev;

  assign updEvt = mstEn && (mstCount == mstReload);
  assign cmpOut = (mstCount >= mstCmp);

  // master trigger-output source
  always_comb begin
    if (mstMode == MMS_UPDATE)  mstTrg = updEvt;
    else if (mstMode[2])        mstTrg = cmpOut;
    else                        mstTrg = 1'b0;
  end

  // internal trigger inputs: input 0 is the master link, the rest unused
  generate
    for (genvar i = 0; i < NUM_ITR; i++) begin : g_itr
      if (i == 0) begin : g_link
        assign itrVec[i] = mstTrg;
      end else begin : g_tie
        assign itrVec[i] = 1'b0;
      end
    end
  endgenerate

  assign slvTrgIn = slvTrigSel[2] ? itrVec[slvTrigSel[SEL_W-1:0]] : 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trgPrev <= 1'b0;
    else       trgPrev <= slvTrgIn;
  end

  assign strobes.mstInc = mstEn;
  assign strobes.mstClr = updEvt;
  assign strobes.slvInc = slvEn && (slvMode == SMS_EXTCLK) && slvTrgIn && !trgPrev;

  // R2: the update event sends the master back to zero
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    (mstEn && mstCount == mstReload) |=> (mstCount == '0));

  // R2: a disabled master holds its count
  a_r2_hold_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !mstEn |=> $stable(mstCount));

  // R5: a quiet master mode never produces a slave step
  a_r5_quiet_mode: assert property (@(posedge clk) disable iff (!rstN)
    (mstMode == MMS_NONE) |-> !strobes.slvInc);
endmodule

// File: rtl/tmr_chain_dp.sv
module tmr_chain_dp
  import tmr_chain_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobes_t  strobes,
  output logic [W-1:0] mstCount,
  output logic [W-1:0] slvCount
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                mstCount <= '0;
    else if (strobes.mstClr)  mstCount <= '0;
    else if (strobes.mstInc)  mstCount <= mstCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                slvCount <= '0;
    else if (strobes.slvInc)  slvCount <= slvCount + 1'b1;
  end

  // R3: a slave step adds exactly one, modulo 2^W (R10)
  a_r10_slave_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.slvInc |=> (slvCount == $past(slvCount) + 1'b1));

  // R7: no step, no change
  a_r7_slave_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.slvInc |=> $stable(slvCount));
endmodule

// File: rtl/tmr_chain_link.sv
module tmr_chain_link
  import tmr_chain_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         mstEn,
  input  logic         slvEn,
  input  logic [2:0]   mstMode,
  input  logic [2:0]   slvTrigSel,
  input  logic [2:0]   slvMode,
  input  logic [W-1:0] mstReload,
  input  logic [W-1:0] mstCmp,
  output logic [W-1:0] mstCount,
  output logic [W-1:0] slvCount
);
  ctlStrobes_t strobes;

  tmr_chain_ctl #(.W(W)) ctl_i (
    .clk(clk), .rstN(rstN), .mstEn(mstEn), .slvEn(slvEn),
    .mstMode(mstMode), .slvTrigSel(slvTrigSel), .slvMode(slvMode),
    .mstReload(mstReload), .mstCmp(mstCmp), .mstCount(mstCount),
    .strobes(strobes)
  );

  tmr_chain_dp #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .mstCount(mstCount), .slvCount(slvCount)
  );

  // R8: a disabled slave keeps its count
  a_r8_slave_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !slvEn |=> $stable(slvCount));

  // R6: a slave not linked to the master stays put
  a_r6_unlinked: assert property (@(posedge clk) disable iff (!rstN)
    (slvTrigSel != 3'b100) |=> $stable(slvCount));

  // R1: counts are zero while reset is held
  always @(posedge clk) begin
    if (!rstN) a_r1_reset_zero: assert (mstCount == '0 && slvCount == '0);
  end
endmodule

// File: tb/tmr_chain_link_tb.sv
module tmr_chain_link_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         mstEn = 1'b0;
  logic         slvEn = 1'b0;
  logic [2:0]   mstMode = 3'b010;
  logic [2:0]   slvTrigSel = 3'b100;
  logic [2:0]   slvMode = 3'b111;
  logic [W-1:0] mstReload = 8'd4;
  logic [W-1:0] mstCmp = 8'd2;
  logic [W-1:0] mstCount;
  logic [W-1:0] slvCount;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_chain_link #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN), .mstEn(mstEn), .slvEn(slvEn),
    .mstMode(mstMode), .slvTrigSel(slvTrigSel), .slvMode(slvMode),
    .mstReload(mstReload), .mstCmp(mstCmp),
    .mstCount(mstCount), .slvCount(slvCount)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runEdges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // configure with both timers off, then pulse reset
  task automatic setup(logic [2:0] mm, logic [2:0] ts, logic [2:0] sm,
                       int rel, int cmp);
    @(negedge clk);
    mstEn = 0; slvEn = 0;
    mstMode = mm; slvTrigSel = ts; slvMode = sm;
    mstReload = W'(rel); mstCmp = W'(cmp);
    rstN = 0;
    runEdges(2);
    rstN = 1;
  endtask

  task automatic t_reset();
    setup(3'b010, 3'b100, 3'b111, 4, 2);
    check("R1 master", int'(mstCount), 0);
    check("R1 slave", int'(slvCount), 0);
  endtask

  task automatic t_prescale();
    setup(3'b010, 3'b100, 3'b111, 4, 2);
    mstEn = 1; slvEn = 1;
    runEdges(4);
    check("R2 master count", int'(mstCount), 4);
    check("R3 slave before wrap", int'(slvCount), 0);
    runEdges(1);
    check("R2 R3 master wrapped", int'(mstCount), 0);
    check("R3 slave same edge", int'(slvCount), 1);
    runEdges(18);
    check("R3 master after 23", int'(mstCount), 3);
    check("R3 slave after 23", int'(slvCount), 4);
    mstEn = 0;
    runEdges(6);
    check("R2 master hold", int'(mstCount), 3);
    check("R2 slave hold", int'(slvCount), 4);
  endtask

  task automatic t_compare();
    setup(3'b100, 3'b100, 3'b111, 4, 2);
    mstEn = 1; slvEn = 1;
    runEdges(2);
    check("R4 no step before match", int'(slvCount), 0);
    runEdges(1);
    check("R4 step after match", int'(slvCount), 1);
    runEdges(9);
    check("R4 slave after 12", int'(slvCount), 2);
    runEdges(1);
    check("R4 slave after 13", int'(slvCount), 3);
    setup(3'b111, 3'b100, 3'b111, 4, 2);
    mstEn = 1; slvEn = 1;
    runEdges(13);
    check("R4 mode 111", int'(slvCount), 3);
  endtask

  task automatic t_quiet();
    logic [2:0] codes[3] = '{3'b000, 3'b001, 3'b011};
    foreach (codes[i]) begin
      setup(codes[i], 3'b100, 3'b111, 4, 2);
      mstEn = 1; slvEn = 1;
      runEdges(30);
      check("R5 master runs", int'(mstCount), 0);
      check("R5 slave idle", int'(slvCount), 0);
    end
  endtask

  task automatic t_select();
    logic [2:0] codes[3] = '{3'b000, 3'b101, 3'b011};
    foreach (codes[i]) begin
      setup(3'b010, codes[i], 3'b111, 4, 2);
      mstEn = 1; slvEn = 1;
      runEdges(23);
      check("R6 unlinked slave", int'(slvCount), 0);
    end
  endtask

  task automatic t_slvMode();
    logic [2:0] codes[3] = '{3'b000, 3'b110, 3'b100};
    foreach (codes[i]) begin
      setup(3'b010, 3'b100, codes[i], 4, 2);
      mstEn = 1; slvEn = 1;
      runEdges(23);
      check("R7 slave mode hold", int'(slvCount), 0);
    end
  endtask

  task automatic t_gate();
    // slave enabled late: overflow at edge 5 lost, edges 10 and 15 counted
    setup(3'b010, 3'b100, 3'b111, 4, 2);
    mstEn = 1;
    runEdges(7);
    check("R8 late slave idle", int'(slvCount), 0);
    slvEn = 1;
    runEdges(10);
    check("R8 late slave count", int'(slvCount), 2);
    check("R8 master count", int'(mstCount), 2);
    // slave disabled in the overflow cycle
    setup(3'b010, 3'b100, 3'b111, 4, 2);
    mstEn = 1; slvEn = 1;
    runEdges(4);
    slvEn = 0;
    runEdges(1);
    check("R8 collide master", int'(mstCount), 0);
    check("R8 collide slave", int'(slvCount), 0);
  endtask

  task automatic t_zeroReload();
    setup(3'b010, 3'b100, 3'b111, 0, 2);
    mstEn = 1; slvEn = 1;
    runEdges(20);
    check("R9 master stays 0", int'(mstCount), 0);
    check("R9 slave once", int'(slvCount), 1);
  endtask

  task automatic t_slvWrap();
    setup(3'b010, 3'b100, 3'b111, 1, 2);
    mstEn = 1; slvEn = 1;
    runEdges(510);
    check("R10 slave 255", int'(slvCount), 255);
    runEdges(2);
    check("R10 slave wrapped", int'(slvCount), 0);
    runEdges(2);
    check("R10 slave after wrap", int'(slvCount), 1);
  endtask

  initial begin
    t_reset();
    t_prescale();
    t_compare();
    t_quiet();
    t_select();
    t_slvMode();
    t_gate();
    t_zeroReload();
    t_slvWrap();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule